// File: doc/BRIEF.md
# Paged SPI EEPROM Slave Model

This block is a synthesizable SPI slave that behaves like a small byte-addressed serial EEPROM. The array is organized in pages. A host issues single-byte opcodes over an SPI mode-0 link, most significant bit first. It can set a write-enable latch, stream a page write, stream a sequential read, poll a status byte, and lock or unlock the array against writes. The block samples the SPI pins with its own system clock through synchronizers, so SCK must be slow compared with `clk`. A half period of eight `clk` cycles is comfortable.

A write does not go straight into the array. Its data bytes fill a page-sized staging buffer, and the in-page offset wraps back to the start of the page. When chip select goes high, every staged byte is copied into the addressed page in one cycle. A busy countdown then stands in for the programming time. While busy, the block answers only status reads and discards every other command.

Top module: `spi_paged_eeprom`

## Requirements
- R1: After reset every array byte reads 0xFF, and the status byte reads 0x00.
- R2: Opcode 0x06 sets the write-enable latch, which is shown in status bit 1.
- R3: Opcode 0x02 is followed by one address byte and then data bytes. Only the low ADDR_W bits of the address byte are used. The data bytes go to consecutive addresses and reach the array when chip select rises.
- R4: During a write the in-page offset (the low PAGE_W address bits) wraps from the page's last byte to its first. With 8-byte pages, writing values 0..7 from offset 4 leaves 4,5,6,7,0,1,2,3 at offsets 0..7.
- R5: A write longer than a page overwrites earlier bytes of the same page, so the last byte sent to an offset wins. No other page changes.
- R6: The write-enable latch clears when chip select rises to end any write command, whether or not that write was accepted.
- R7: A write issued while the write-enable latch is clear leaves the array unchanged and does not start busy.
- R8: Opcode 0x0B sets the lock, shown in status bit 2. While the lock is set, writes leave the array unchanged. Opcode 0x0C clears the lock.
- R9: Status bit 0 (busy) is set for BUSY_CYCLES clock cycles after a write commits. While busy, every opcode except 0x05 is ignored until chip select rises, and MISO stays low.
- R10: Opcode 0x03 is followed by an address byte. The block then returns bytes from consecutive addresses, crossing page boundaries, and wraps from the last array address to address 0.
- R11: A write that ends before one full data byte has been received commits nothing and does not start busy.
- R12: Opcode 0x05 returns the status byte {5'b0, lock, write-enable, busy}, repeated for as long as clocking continues. All bytes are MSB first, sampled on SCK rise and driven on SCK fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
Each SPI pin passes through SYNC_STAGES flops plus one edge-detect flop. A received byte is therefore recognized about three `clk` cycles after its eighth SCK rise. The reply byte is loaded one cycle later, and its bits move on later SCK falls. The bench holds each SCK phase for eight `clk` cycles and samples MISO just before raising SCK, well after the reply bit has settled. A commit happens three to four cycles after chip select rises, and busy then runs for BUSY_CYCLES cycles. The bench reads status about 140 cycles after a write ends, so busy must still be set. It issues an ignored read around 300 cycles after the write. Before treating the array as idle, it waits BUSY_CYCLES plus a margin.

// File: rtl/speep_pkg.sv
package speep_pkg;

   localparam logic [7:0] OPC_WEL_SET  = 8'h06;
   localparam logic [7:0] OPC_WRITE    = 8'h02;
   localparam logic [7:0] OPC_READ     = 8'h03;
   localparam logic [7:0] OPC_STATUS   = 8'h05;
   localparam logic [7:0] OPC_LOCK     = 8'h0B;
   localparam logic [7:0] OPC_UNLOCK   = 8'h0C;

   localparam int BYTE_BITS = 8;

   typedef enum logic [2:0] {
      ST_OPCODE,
      ST_WR_ADDR,
      ST_WR_DATA,
      ST_RD_ADDR,
      ST_RD_DATA,
      ST_STATUS,
      ST_DISCARD
   } cmd_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_q,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   if (STAGES < 2) begin : g_chk_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   // Last entry is one cycle older than the synchronized value, for edges.
   logic [STAGES:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s <= STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= pin_in;
         for (int s = 1; s <= STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign pin_q = chain_q[STAGES-1];

   for (genvar b = 0; b < WIDTH; b++) begin : g_edge
      assign rise[b] =  chain_q[STAGES-1][b] & ~chain_q[STAGES][b];
      assign fall[b] = ~chain_q[STAGES-1][b] &  chain_q[STAGES][b];
   end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
   import speep_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 sck_rise,
   input  logic                 sck_fall,
   input  logic                 mosi_s,
   input  logic                 tx_load,
   input  logic [BYTE_BITS-1:0] tx_byte,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic                 rx_done,
   output logic                 miso
);

   localparam int CNT_W = $clog2(BYTE_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

   logic [CNT_W-1:0]     bit_cnt_q;
   logic [BYTE_BITS-1:0] rx_sh_q;
   logic [BYTE_BITS-1:0] tx_sh_q;
   logic                 done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         rx_sh_q   <= '0;
         tx_sh_q   <= '0;
         done_q    <= 1'b0;
      end else if (!sel) begin
         bit_cnt_q <= '0;
         tx_sh_q   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (sck_rise) begin
            rx_sh_q   <= {rx_sh_q[BYTE_BITS-2:0], mosi_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) done_q <= 1'b1;
         end
         // A fresh reply byte already shows its MSB; the fall right after a
         // byte boundary must not shift it away.
         if (tx_load) begin
            tx_sh_q <= tx_byte;
         end else if (sck_fall && bit_cnt_q != '0) begin
            tx_sh_q <= {tx_sh_q[BYTE_BITS-2:0], 1'b0};
         end
      end
   end

   assign rx_byte = rx_sh_q;
   assign rx_done = done_q;
   assign miso    = tx_sh_q[BYTE_BITS-1];

endmodule

// File: rtl/page_stage_buffer.sv
module page_stage_buffer
   import speep_pkg::*;
#(
   parameter int PAGE_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [PAGE_W-1:0]               start_off,
   input  logic                            wr_en,
   input  logic [BYTE_BITS-1:0]            wr_byte,
   output logic [PAGE_W-1:0]               cur_off,
   output logic [(1<<PAGE_W)-1:0]          lane_mask,
   output logic [(1<<PAGE_W)*BYTE_BITS-1:0] lane_data
);

   localparam int LANES = 1 << PAGE_W;

   logic [BYTE_BITS-1:0] data_q [LANES];
   logic [LANES-1:0]     mask_q;
   logic [PAGE_W-1:0]    off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LANES; i++) data_q[i] <= '0;
         mask_q <= '0;
         off_q  <= '0;
      end else if (start) begin
         mask_q <= '0;
         off_q  <= start_off;
      end else if (wr_en) begin
         data_q[off_q] <= wr_byte;
         mask_q[off_q] <= 1'b1;
         off_q         <= off_q + 1'b1;   // natural wrap inside the page
      end
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign lane_data[b*BYTE_BITS +: BYTE_BITS] = data_q[b];
   end

   assign lane_mask = mask_q;
   assign cur_off   = off_q;

endmodule

// File: rtl/paged_byte_array.sv
module paged_byte_array
   import speep_pkg::*;
#(
   parameter int                   ADDR_W = 6,
   parameter int                   PAGE_W = 3,
   parameter logic [BYTE_BITS-1:0] FILL   = 8'hFF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                rd_addr,
   output logic [BYTE_BITS-1:0]             rd_data,
   input  logic                             commit,
   input  logic [ADDR_W-PAGE_W-1:0]         commit_page,
   input  logic [(1<<PAGE_W)-1:0]           commit_mask,
   input  logic [(1<<PAGE_W)*BYTE_BITS-1:0] commit_data
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 1 << PAGE_W;

   logic [BYTE_BITS-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= FILL;
      end else if (commit) begin
         for (int b = 0; b < LANES; b++) begin
            if (commit_mask[b]) begin
               mem_q[{commit_page, PAGE_W'(b)}] <= commit_data[b*BYTE_BITS +: BYTE_BITS];
            end
         end
      end
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spi_paged_eeprom.sv
module spi_paged_eeprom
   import speep_pkg::*;
#(
   parameter int                   ADDR_W      = 6,
   parameter int                   PAGE_W      = 3,
   parameter int                   BUSY_CYCLES = 1000,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [BYTE_BITS-1:0] FILL        = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int PAGES_W = ADDR_W - PAGE_W;
   localparam int LANES   = 1 << PAGE_W;
   localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);

   if (ADDR_W < 2 || ADDR_W > BYTE_BITS) begin : g_chk_addr
      $error("spi_paged_eeprom: ADDR_W must lie in 2..8");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_chk_page
      $error("spi_paged_eeprom: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (BUSY_CYCLES < 1) begin : g_chk_busy
      $error("spi_paged_eeprom: BUSY_CYCLES must be positive");
   end

   // ---------------- pin synchronization (bit0 sck, bit1 cs_n, bit2 mosi)
   logic [2:0] pins_s, pins_rise, pins_fall;

   spi_pin_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (3),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in ({spi_mosi, spi_cs_n, spi_sck}),
      .pin_q  (pins_s),
      .rise   (pins_rise),
      .fall   (pins_fall)
   );

   logic sel, cs_rise, unused_pins;
   assign sel         = ~pins_s[1];
   assign cs_rise     = pins_rise[1];
   assign unused_pins = ^{pins_rise[2], pins_fall[2], pins_fall[1], pins_s[0]};

   // ---------------- byte engine
   logic [BYTE_BITS-1:0] rx_byte, tx_byte;
   logic                 rx_done, tx_load;

   spi_byte_engine u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .sck_rise (pins_rise[0]),
      .sck_fall (pins_fall[0]),
      .mosi_s   (pins_s[2]),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte),
      .rx_byte  (rx_byte),
      .rx_done  (rx_done),
      .miso     (spi_miso)
   );

   // ---------------- command state
   cmd_state_t          state_q, state_d;
   logic                wel_q, wel_d;
   logic                lock_q, lock_d;
   logic                wr_cmd_q, wr_cmd_d;   // current transaction is a write
   logic                wr_ok_q, wr_ok_d;     // and it was accepted
   logic [PAGES_W-1:0]  page_q, page_d;
   logic [ADDR_W-1:0]   addr_q, addr_d;
   logic [BUSY_W-1:0]   busy_cnt_q;
   logic                busy;

   logic                buf_start, buf_we, rd_step, commit;
   logic [PAGE_W-1:0]   buf_off;
   logic [LANES-1:0]    buf_mask;
   logic [LANES*BYTE_BITS-1:0] buf_data;

   logic [ADDR_W-1:0]    rx_addr, rd_addr;
   logic [BYTE_BITS-1:0] rd_data, status_byte;

   assign busy        = (busy_cnt_q != '0);
   assign rx_addr     = rx_byte[ADDR_W-1:0];
   assign status_byte = {{(BYTE_BITS-3){1'b0}}, lock_q, wel_q, busy};
   assign rd_addr     = (state_q == ST_RD_ADDR) ? rx_addr : addr_q;
   assign commit      = cs_rise & wr_ok_q & (|buf_mask);

   always_comb begin
      state_d   = state_q;
      wel_d     = wel_q;
      lock_d    = lock_q;
      wr_cmd_d  = wr_cmd_q;
      wr_ok_d   = wr_ok_q;
      page_d    = page_q;
      addr_d    = addr_q;
      tx_load   = 1'b0;
      tx_byte   = '0;
      buf_start = 1'b0;
      buf_we    = 1'b0;
      rd_step   = 1'b0;

      if (cs_rise) begin
         state_d  = ST_OPCODE;
         wr_cmd_d = 1'b0;
         wr_ok_d  = 1'b0;
         if (wr_cmd_q) wel_d = 1'b0;
      end else if (rx_done) begin
         unique case (state_q)
            ST_OPCODE: begin
               state_d = ST_DISCARD;
               if (busy) begin
                  if (rx_byte == OPC_STATUS) begin
                     state_d = ST_STATUS;
                     tx_load = 1'b1;
                     tx_byte = status_byte;
                  end
               end else begin
                  unique case (rx_byte)
                     OPC_WEL_SET: wel_d  = 1'b1;
                     OPC_LOCK:    lock_d = 1'b1;
                     OPC_UNLOCK:  lock_d = 1'b0;
                     OPC_WRITE: begin
                        state_d  = ST_WR_ADDR;
                        wr_cmd_d = 1'b1;
                     end
                     OPC_READ:    state_d = ST_RD_ADDR;
                     OPC_STATUS: begin
                        state_d = ST_STATUS;
                        tx_load = 1'b1;
                        tx_byte = status_byte;
                     end
                     default: ;
                  endcase
               end
            end
            ST_WR_ADDR: begin
               state_d   = ST_WR_DATA;
               buf_start = 1'b1;
               page_d    = rx_addr[ADDR_W-1:PAGE_W];
               wr_ok_d   = wel_q & ~lock_q;
            end
            ST_WR_DATA: buf_we = wr_ok_q;
            ST_RD_ADDR: begin
               state_d = ST_RD_DATA;
               tx_load = 1'b1;
               tx_byte = rd_data;
               addr_d  = rx_addr + 1'b1;
            end
            ST_RD_DATA: begin
               tx_load = 1'b1;
               tx_byte = rd_data;
               addr_d  = addr_q + 1'b1;   // wraps at the array end
               rd_step = 1'b1;
            end
            ST_STATUS: begin
               tx_load = 1'b1;
               tx_byte = status_byte;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OPCODE;
         wel_q    <= 1'b0;
         lock_q   <= 1'b0;
         wr_cmd_q <= 1'b0;
         wr_ok_q  <= 1'b0;
         page_q   <= '0;
         addr_q   <= '0;
      end else begin
         state_q  <= sel ? state_d : ST_OPCODE;
         wel_q    <= wel_d;
         lock_q   <= lock_d;
         wr_cmd_q <= wr_cmd_d;
         wr_ok_q  <= wr_ok_d;
         page_q   <= page_d;
         addr_q   <= addr_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt_q <= '0;
      else if (commit) busy_cnt_q <= BUSY_W'(BUSY_CYCLES);
      else if (busy)   busy_cnt_q <= busy_cnt_q - 1'b1;
   end

   // ---------------- staging buffer and storage
   page_stage_buffer #(.PAGE_W(PAGE_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (buf_start),
      .start_off (rx_addr[PAGE_W-1:0]),
      .wr_en     (buf_we),
      .wr_byte   (rx_byte),
      .cur_off   (buf_off),
      .lane_mask (buf_mask),
      .lane_data (buf_data)
   );

   paged_byte_array #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .FILL   (FILL)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .commit      (commit),
      .commit_page (page_q),
      .commit_mask (buf_mask),
      .commit_data (buf_data)
   );

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker #(
   parameter int ADDR_W      = 6,
   parameter int PAGE_W      = 3,
   parameter int BUSY_CYCLES = 1000
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              cs_rise,
   input logic                              commit,
   input logic [$clog2(BUSY_CYCLES+1)-1:0]  busy_cnt,
   input logic                              lock_q,
   input logic                              wel_q,
   input logic                              wr_cmd_q,
   input logic                              buf_we,
   input logic [PAGE_W-1:0]                 buf_off,
   input logic                              rd_step,
   input logic [ADDR_W-1:0]                 addr_q
);

   localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

   // R9: a commit loads the full busy window
   p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy_cnt == BUSY_W'(BUSY_CYCLES));

   // R9: busy counts down one per cycle
   p_busy_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt != '0 && !commit) |=> busy_cnt == $past(busy_cnt) - 1'b1);

   // R9: no commit while the previous one is still programming
   p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> busy_cnt == '0);

   // R8: the lock blocks every commit
   p_no_commit_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !lock_q);

   // R7: a commit needs the write-enable latch
   p_commit_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> wel_q);

   // R6: the latch is gone after a write transaction ends
   p_wel_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && wr_cmd_q) |=> !wel_q);

   // R4: staging offset wraps inside the page
   p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_off == {PAGE_W{1'b1}}) |=> buf_off == '0);

   // R10: read pointer wraps at the array end
   p_read_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_step && addr_q == {ADDR_W{1'b1}}) |=> addr_q == '0);

endmodule

bind spi_paged_eeprom eeprom_checker #(
   .ADDR_W      (ADDR_W),
   .PAGE_W      (PAGE_W),
   .BUSY_CYCLES (BUSY_CYCLES)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_rise  (cs_rise),
   .commit   (commit),
   .busy_cnt (busy_cnt_q),
   .lock_q   (lock_q),
   .wel_q    (wel_q),
   .wr_cmd_q (wr_cmd_q),
   .buf_we   (buf_we),
   .buf_off  (buf_off),
   .rd_step  (rd_step),
   .addr_q   (addr_q)
);

// File: tb/test_spi_paged_eeprom.sv
`timescale 1ns/1ps
module test_spi_paged_eeprom;

   localparam int ADDR_W = 6;
   localparam int PAGE_W = 3;
   localparam int BUSY   = 1000;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PSIZE  = 1 << PAGE_W;
   localparam int HALF   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;

   always #10 clk = ~clk;   // 50 MHz

   spi_paged_eeprom #(
      .ADDR_W      (ADDR_W),
      .PAGE_W      (PAGE_W),
      .BUSY_CYCLES (BUSY)
   ) i_spi_paged_eeprom (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (sck),
      .spi_cs_n (cs_n),
      .spi_mosi (mosi),
      .spi_miso (miso)
   );

   int total = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] model [DEPTH];
   logic [7:0] rbuf  [80];

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic bits(input logic [7:0] tx, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic sel_on();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sel_off();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic opcode_only(input logic [7:0] op);
      logic [7:0] d;
      sel_on(); xfer(op, d); sel_off();
   endtask

   task automatic get_status(output logic [7:0] s);
      logic [7:0] d;
      sel_on(); xfer(8'h05, d); xfer(8'h00, s); sel_off();
   endtask

   task automatic write_run(input logic [7:0] addr, input int n, input logic [7:0] base);
      logic [7:0] d;
      sel_on(); xfer(8'h02, d); xfer(addr, d);
      for (int i = 0; i < n; i++) xfer(base + 8'(i), d);
      sel_off();
   endtask

   task automatic read_run(input logic [7:0] addr, input int n);
      logic [7:0] d;
      sel_on(); xfer(8'h03, d); xfer(addr, d);
      for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
      sel_off();
   endtask

   // expected effect of an accepted write, from R3/R4/R5
   task automatic model_write(input int addr, input int n, input logic [7:0] base);
      int a = addr % DEPTH;
      for (int i = 0; i < n; i++)
         model[(a / PSIZE) * PSIZE + ((a % PSIZE) + i) % PSIZE] = base + 8'(i);
   endtask

   task automatic wait_idle();
      repeat (BUSY + 50) @(negedge clk);
   endtask

   task automatic compare_all(input string req);
      int bad = 0;
      int first = -1;
      read_run(8'h00, DEPTH);
      for (int i = 0; i < DEPTH; i++)
         if (rbuf[i] !== model[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (bad == 0) check(req, 8'h00, 8'h00);
      else check(req, rbuf[first], model[first]);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++; total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] s, d, s1, s2, s3;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      get_status(s);
      check("R1 status after reset", s, 8'h00);
      compare_all("R1 R10 array erased after reset");

      // R2 latch set
      opcode_only(8'h06);
      get_status(s);
      check("R2 write-enable shown", s, 8'h02);

      // R4 documented wrap example: 0..7 from offset 4 of page 2
      write_run(8'h14, 8, 8'h00);
      model_write(8'h14, 8, 8'h00);
      get_status(s);
      check("R9 R6 busy set, latch clear after write", s, 8'h01);
      read_run(8'h10, 1);
      check("R9 read ignored while busy", rbuf[0], 8'h00);
      wait_idle();
      get_status(s);
      check("R9 busy over after window", s, 8'h00);
      read_run(8'h10, PSIZE);
      for (int k = 0; k < PSIZE; k++)
         check("R4 wrap example", rbuf[k], 8'((k + 4) % 8));

      // R5 overlong write into page 5 starting at offset 2
      opcode_only(8'h06);
      write_run(8'h2A, 13, 8'hA0);
      model_write(8'h2A, 13, 8'hA0);
      wait_idle();
      compare_all("R5 overlong write stays in page");

      // R7 write without latch
      write_run(8'h00, 1, 8'h55);
      get_status(s);
      check("R7 no busy without latch", s, 8'h00);

      // R8 lock blocks an enabled write
      opcode_only(8'h06);
      opcode_only(8'h0B);
      get_status(s);
      check("R8 lock and latch shown", s, 8'h06);
      write_run(8'h08, 2, 8'h77);
      get_status(s);
      check("R8 R6 no busy while locked, latch cleared", s, 8'h04);
      opcode_only(8'h0C);
      get_status(s);
      check("R8 unlock clears lock", s, 8'h00);
      compare_all("R7 R8 array unchanged");

      // R3 single byte, upper address bits ignored (0xC8 -> 0x08)
      opcode_only(8'h06);
      write_run(8'hC8, 1, 8'h3C);
      model_write(8'h08, 1, 8'h3C);
      wait_idle();
      read_run(8'h07, 3);
      check("R3 byte before untouched", rbuf[0], model[7]);
      check("R3 written byte", rbuf[1], 8'h3C);
      check("R3 byte after untouched", rbuf[2], model[9]);

      // R11 write with no complete data byte
      opcode_only(8'h06);
      write_run(8'h18, 0, 8'h00);
      get_status(s);
      check("R11 R6 address-only write", s, 8'h00);
      opcode_only(8'h06);
      sel_on(); xfer(8'h02, d); xfer(8'h18, d); bits(8'h99, 5); sel_off();
      get_status(s);
      check("R11 partial data byte", s, 8'h00);
      read_run(8'h18, 1);
      check("R11 array untouched", rbuf[0], model[8'h18]);

      // R10 read across the array end
      read_run(8'h3C, 8);
      for (int k = 0; k < 8; k++)
         check("R10 read wrap", rbuf[k], model[(8'h3C + k) % DEPTH]);

      // R12 repeated status bytes
      opcode_only(8'h0B);
      sel_on(); xfer(8'h05, d); xfer(8'h00, s1); xfer(8'h00, s2); xfer(8'h00, s3); sel_off();
      check("R12 status byte 1", s1, 8'h04);
      check("R12 status byte 2", s2, 8'h04);
      check("R12 status byte 3", s3, 8'h04);
      opcode_only(8'h0C);

      // R4 sweep of every start offset in the last page
      for (int off = 0; off < PSIZE; off++) begin
         opcode_only(8'h06);
         write_run(8'(8'h38 + off), PSIZE, 8'(8'h80 + 8 * off));
         model_write(8'h38 + off, PSIZE, 8'(8'h80 + 8 * off));
         wait_idle();
         read_run(8'h38, PSIZE);
         for (int k = 0; k < PSIZE; k++)
            check("R4 offset sweep", rbuf[k], model[8'h38 + k]);
      end
      compare_all("R5 R10 final array");

      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule